// File: doc/BRIEF.md
# Deskew Reference Frame Generator

This block produces the extra transmit lane that travels next to a bundle of parallel data lanes. On that lane it sends a fixed-length reference frame over and over with no gap. Each frame opens with a short fixed header and then carries copies of live traffic taken from every data lane in turn. A receiver locks onto the header and compares each data lane with its copy in the frame. From that comparison it learns how much each lane is skewed.

The deskew word leaves through an output register, so it comes one clock after the data words it samples. The data lanes must pass through one matching register on their way to the serialisers so that both stay aligned. A one-cycle strobe marks the first word of every frame. Bit reversal for serial order and the transceivers themselves sit outside this block.

Top module: `dskw_ref_frame_gen`

## Requirements
- R1: While `rst` is sampled high at a rising edge, the next output is `dsk_word_o` = 0 and `frame_start_o` = 0. The first word after reset is released is frame word 0.
- R2: Frame word 0 is 0xF6F6 and frame word 1 is 0x2828.
- R3: Frame words 2 and 3 are both 0xAAAA.
- R4: Frame word k, for 4 <= k <= 67, is the word on data lane 15 - (k-4)/4 in the cycle before that word appears on the output. Lane n occupies bits [16n+15:16n] of `lane_data_i`. The lanes are therefore sampled from 15 down to 0, with four consecutive words from each lane.
- R5: A frame is 68 words long and frames follow each other with no gap, so `frame_start_o` rises exactly every 68 cycles.
- R6: `frame_start_o` is high for exactly one cycle, and only while word 0 (0xF6F6) is on `dsk_word_o`.
- R7: A reset asserted in the middle of a frame stops that frame. After release the block starts again at word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lane_data_i | input | 256 | Sixteen 16-bit data lane words, lane n at [16n+15:16n] |
| dsk_word_o | output | 16 | Registered deskew lane word |
| frame_start_o | output | 1 | High while frame word 0 is on `dsk_word_o` |

## Verification
The hardest case to reach from the ports is proving that each sample slot takes its value from the right lane in the right cycle. The lanes change every clock, and a wrong lane or a one-cycle slip is visible only if every lane holds a different value in every cycle. The bench therefore drives fresh random words on all sixteen lanes at each clock and checks every output word against a behavioural frame model. It then pulls reset in the middle of the sample area, so that a restart from a non-zero word index is exercised as well.

// File: rtl/dskw_pkg.sv
package dskw_pkg;

    // Default geometry of the deskew lane
    localparam int DATA_LANES       = 16;
    localparam int LANE_WORD_W      = 16;
    localparam int WORDS_PER_LANE   = 4;
    localparam int SYNC_WORDS       = 2;
    localparam int EXT_WORDS        = 2;
    localparam int HEADER_WORDS     = SYNC_WORDS + EXT_WORDS;

    // Byte patterns that make up the header words
    localparam logic [7:0] SYNC_BYTE_A = 8'hF6;
    localparam logic [7:0] SYNC_BYTE_B = 8'h28;
    localparam logic [7:0] EXT_BYTE    = 8'hAA;

    typedef enum logic [1:0] {
        SLOT_SYNC   = 2'd0,
        SLOT_EXT    = 2'd1,
        SLOT_SAMPLE = 2'd2
    } slot_kind_e;

    // What the current frame position carries
    typedef struct packed {
        slot_kind_e  kind;
        logic        second;   // second word of a two-word header
        logic [7:0]  lane;     // lane to copy when kind is SLOT_SAMPLE
    } slot_t;

    // Header word for a given slot, built by replicating a byte
    function automatic logic [LANE_WORD_W-1:0] header_word(input slot_t s);
        logic [7:0] b;
        case (s.kind)
            SLOT_SYNC: b = s.second ? SYNC_BYTE_B : SYNC_BYTE_A;
            SLOT_EXT:  b = EXT_BYTE;
            default:   b = 8'h00;
        endcase
        return {(LANE_WORD_W/8){b}};
    endfunction

endpackage

// File: rtl/dskw_slot_counter.sv
module dskw_slot_counter
    import dskw_pkg::*;
#(
    parameter int LANES     = DATA_LANES,
    parameter int SPL       = WORDS_PER_LANE,
    parameter int HDR_WORDS = HEADER_WORDS,
    parameter int SYNC_LEN  = SYNC_WORDS
) (
    input  logic  clk,
    input  logic  rst,
    output logic  at_start,
    output slot_t slot
);
    localparam int FRAME_LEN = HDR_WORDS + LANES * SPL;
    localparam int CNT_W     = $clog2(FRAME_LEN);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] samp_idx;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign at_start = (cnt == '0);
    assign samp_idx = cnt - CNT_W'(HDR_WORDS);

    always_comb begin
        slot = '0;
        if (cnt < CNT_W'(SYNC_LEN)) begin
            slot.kind   = SLOT_SYNC;
            slot.second = (cnt != '0);
        end else if (cnt < CNT_W'(HDR_WORDS)) begin
            slot.kind   = SLOT_EXT;
            slot.second = (cnt != CNT_W'(SYNC_LEN));
        end else begin
            slot.kind   = SLOT_SAMPLE;
            slot.lane   = 8'(LANES - 1) - 8'(samp_idx / CNT_W'(SPL));
        end
    end

    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
        (cnt == LAST) |=> (cnt == '0)); // R5
    AST_FRAME_STEP: assert property (@(posedge clk) disable iff (rst)
        (cnt != LAST) |=> (cnt == CNT_W'($past(cnt) + 1'b1))); // R5
    AST_LANE_RANGE: assert property (@(posedge clk) disable iff (rst)
        (slot.kind == SLOT_SAMPLE) |-> (slot.lane < 8'(LANES))); // R4

endmodule

// File: rtl/dskw_lane_select.sv
module dskw_lane_select
    import dskw_pkg::*;
#(
    parameter int LANES  = DATA_LANES,
    parameter int WORD_W = LANE_WORD_W
) (
    input  logic [LANES*WORD_W-1:0] lanes,
    input  logic [7:0]              lane_sel,
    output logic [WORD_W-1:0]       word
);
    logic [WORD_W-1:0] lane_words [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_unpack
        assign lane_words[g] = lanes[g*WORD_W +: WORD_W];
    end

    always_comb begin
        word = '0;
        for (int i = 0; i < LANES; i++) begin
            if (lane_sel == 8'(i)) word = lane_words[i];
        end
    end

endmodule

// File: rtl/dskw_word_build.sv
module dskw_word_build
    import dskw_pkg::*;
#(
    parameter int WORD_W = LANE_WORD_W
) (
    input  slot_t             slot,
    input  logic [WORD_W-1:0] sample_word,
    output logic [WORD_W-1:0] next_word
);
    always_comb begin
        if (slot.kind == SLOT_SAMPLE) next_word = sample_word;
        else                          next_word = header_word(slot);
    end

endmodule

// File: rtl/dskw_ref_frame_gen.sv
module dskw_ref_frame_gen
    import dskw_pkg::*;
#(
    parameter int LANES  = DATA_LANES,
    parameter int WORD_W = LANE_WORD_W,
    parameter int SPL    = WORDS_PER_LANE
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [LANES*WORD_W-1:0] lane_data_i,
    output logic [WORD_W-1:0]       dsk_word_o,
    output logic                    frame_start_o
);
    localparam logic [WORD_W-1:0] SYNC_A = {(WORD_W/8){SYNC_BYTE_A}};
    localparam logic [WORD_W-1:0] SYNC_B = {(WORD_W/8){SYNC_BYTE_B}};
    localparam logic [WORD_W-1:0] EXT_W  = {(WORD_W/8){EXT_BYTE}};

    slot_t             slot;
    logic              at_start;
    logic [WORD_W-1:0] sample_word;
    logic [WORD_W-1:0] next_word;

    dskw_slot_counter #(
        .LANES(LANES), .SPL(SPL),
        .HDR_WORDS(HEADER_WORDS), .SYNC_LEN(SYNC_WORDS)
    ) u_slot (
        .clk(clk), .rst(rst), .at_start(at_start), .slot(slot)
    );

    dskw_lane_select #(.LANES(LANES), .WORD_W(WORD_W)) u_sel (
        .lanes(lane_data_i), .lane_sel(slot.lane), .word(sample_word)
    );

    dskw_word_build #(.WORD_W(WORD_W)) u_build (
        .slot(slot), .sample_word(sample_word), .next_word(next_word)
    );

    // Output register: the lane copy uses the pre-register input word
    always_ff @(posedge clk) begin
        if (rst) begin
            dsk_word_o    <= '0;
            frame_start_o <= 1'b0;
        end else begin
            dsk_word_o    <= next_word;
            frame_start_o <= at_start;
        end
    end

    AST_START_ON_SYNC: assert property (@(posedge clk) disable iff (rst)
        frame_start_o |-> (dsk_word_o == SYNC_A)); // R6
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
        frame_start_o |=> !frame_start_o); // R6
    AST_SYNC_SECOND: assert property (@(posedge clk) disable iff (rst)
        frame_start_o |=> (dsk_word_o == SYNC_B)); // R2
    AST_EXT_WORDS: assert property (@(posedge clk) disable iff (rst)
        frame_start_o |=> ##1 (dsk_word_o == EXT_W)); // R3

endmodule

// File: tb/dskw_ref_frame_gen_bench.sv
module dskw_ref_frame_gen_bench;
    localparam int LANES = 16;
    localparam int FLEN  = 68;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [255:0]   lane_data_i = '0;
    logic [15:0]    dsk_word_o;
    logic           frame_start_o;

    int checks = 0;
    int errors = 0;
    int k = 0;            // model frame position
    int cyc = 0;
    int last_start = -1;

    always #4 clk = ~clk; // 125 MHz

    dskw_ref_frame_gen u_dskw_ref_frame_gen (
        .clk(clk), .rst(rst), .lane_data_i(lane_data_i),
        .dsk_word_o(dsk_word_o), .frame_start_o(frame_start_o)
    );

    function automatic logic [15:0] model_word(int pos, logic [255:0] d);
        if (pos == 0) return 16'hF6F6;
        if (pos == 1) return 16'h2828;
        if (pos < 4)  return 16'hAAAA;
        return d[(15 - (pos - 4) / 4) * 16 +: 16];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cyc=%0d pos=%0d actual=%h expected=%h", req, cyc, k, act, exp);
        end
    endtask

    // One clock: drive at negedge, compare just after the next rising edge
    task automatic step(logic r, logic [255:0] d);
        logic [15:0] ew;
        logic        es;
        int          nk;
        string       tag;
        @(negedge clk);
        rst = r;
        lane_data_i = d;
        if (r) begin
            ew = 16'h0; es = 1'b0; nk = 0; tag = "R1/R7";
        end else begin
            ew = model_word(k, d);
            es = (k == 0);
            nk = (k + 1) % FLEN;
            tag = (k < 2) ? "R2" : (k < 4) ? "R3" : "R4";
        end
        @(posedge clk);
        #1;
        cyc++;
        check(tag, {16'h0, dsk_word_o}, {16'h0, ew});
        check("R6", {31'h0, frame_start_o}, {31'h0, es});
        if (!r && frame_start_o) begin
            if (last_start >= 0) check("R5", cyc - last_start, FLEN);
            last_start = cyc;
        end
        if (r) last_start = -1;
        k = nk;
    endtask

    function automatic logic [255:0] rand_lanes();
        logic [255:0] v;
        for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        // R1: outputs held at zero during reset
        for (int i = 0; i < 3; i++) step(1'b1, rand_lanes());
        // R2 R3 R4 R5 R6: three frames with fresh random data every clock
        for (int i = 0; i < 3 * FLEN; i++) step(1'b0, rand_lanes());
        // R4: lane-tagged pattern, each word names its lane and cycle
        for (int i = 0; i < FLEN; i++) begin
            logic [255:0] d;
            for (int n = 0; n < LANES; n++) d[n*16 +: 16] = {4'(n), 12'(i)};
            step(1'b0, d);
        end
        // R7: reset in the middle of the sample area, then restart
        for (int i = 0; i < 30; i++) step(1'b0, rand_lanes());
        step(1'b1, rand_lanes());
        step(1'b1, rand_lanes());
        for (int i = 0; i < 2 * FLEN + 5; i++) step(1'b0, rand_lanes());
        // R4: all-ones and all-zeros lanes at the frame boundary
        for (int i = 0; i < FLEN; i++) step(1'b0, (i % 2 == 0) ? '1 : '0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule